// File: doc/BRIEF.md
# Asynchronous SRAM cycle controller

This block runs single read and write cycles on an external 8192 x 8 asynchronous static RAM from a synchronous clock domain. The host issues one request at a time on a valid/ready port carrying a 13-bit address, a byte of write data and a direction bit. The controller then sequences the chip-select pair, the output-enable and write-enable strobes and the tri-state control of the shared data bus. It returns a one-cycle response pulse when a write has finished or when read data has been latched.

Back-pressure works as follows. `req_ready` is high only while the controller is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and the request fields must be held until that edge. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse, and `rsp_rdata` keeps the last captured byte until the next read completes.

Every analog minimum (access times, pulse width, data setup, write-cycle time, output float time) is given as a nanosecond parameter. Each one is turned into a clock count by rounding up, with a floor of one cycle.

Top module: `sram_ctl`

## Requirements
- R1: During and right after reset, both strobes are high, the chip is deselected (`mem_sel_n`=1, `mem_sel`=0), `mem_dq_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: A request is accepted only while idle. While a cycle is in progress `req_ready` stays low, and request fields presented then and withdrawn before idle change no memory location.
- R3: A write holds `mem_we_n` low, with the chip selected, the bus driven and `mem_oe_n` high, for WR_CYC cycles. WR_CYC is the largest of the rounded-up write pulse, data setup, address-to-end and write-cycle minima, and address and data stay constant for the whole low time.
- R4: The write ends on the rising edge of `mem_we_n`. The chip is deselected and the bus is released on that same clock edge, so hold time is zero.
- R5: A read holds `mem_oe_n` low, `mem_we_n` high and the chip selected, with a steady address, for RD_CYC cycles. RD_CYC is the largest of the rounded-up address-access, output-enable-access and read-cycle minima. `mem_dq_in` is captured on the edge that ends this window.
- R6: After `mem_oe_n` rises, the controller does not drive the bus for FL_CYC cycles, the rounded-up output float time. `req_ready` stays low over that span.
- R7: `mem_dq_oe` is never high while `mem_oe_n` is low.
- R8: Whenever the controller is idle, both strobes are high, the chip is deselected and the bus is released.
- R9: Every accepted request yields exactly one `rsp_valid` pulse of one cycle. The pulse comes WR_CYC clock edges after acceptance for a write and RD_CYC for a read.
- R10: `rsp_rdata` changes only on the edge that raises `rsp_valid` for a read. It holds its value across later writes.
- R11: Each cycle count equals ceil(ns / CLK_NS), with a minimum of 1. At the defaults (10 ns clock) this gives RD_CYC=2, WR_CYC=2 and FL_CYC=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Memory location |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last byte read |
| mem_addr | output | 13 | Address pins of the memory |
| mem_sel_n | output | 1 | Active-low chip enable |
| mem_sel | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_in | input | 8 | Data returned by the memory |
| mem_dq_oe | output | 1 | Tri-state enable for `mem_dq_out` |

## Verification
The bench fills every location with one arithmetic pattern and reads all of them back. A wrong address path shows up as aliasing, and a too-short access window shows up as the garbage byte the memory model returns before its access times elapse. A second pass alternates a write and an immediate read at scattered addresses. This exposes a bus turn-around that is too short, because the model flags any drive while its outputs may still be on. Directed sequences keep a request asserted while the controller is busy, and place a write after a read to confirm that the read byte is retained. Latency to the response pulse is measured on every operation against the counts derived from the nanosecond figures.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2,
    PH_FLOAT = 2'd3
  } phase_t;

  // ceil(ns / clk_ns), never below one cycle
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  // final cycle of the loaded span: the phase changes on the next edge
  assign last = (cnt == CNT_W'(1));

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int RD_CYC = 2,
  parameter int WR_CYC = 2,
  parameter int FL_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             last,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             mem_sel_n,
  output logic             mem_sel,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic             mem_dq_oe,
  output logic             rsp_valid
);

  phase_t ph;

  assign req_ready = (ph == PH_IDLE);

  always_comb begin
    accept   = (ph == PH_IDLE) && req_valid;
    capture  = (ph == PH_READ) && last;
    load     = 1'b0;
    load_val = '0;
    if (accept) begin
      load     = 1'b1;
      load_val = req_write ? CNT_W'(WR_CYC) : CNT_W'(RD_CYC);
    end else if (capture) begin
      load     = 1'b1;
      load_val = CNT_W'(FL_CYC);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      mem_sel_n <= 1'b1;
      mem_sel   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (ph)
        PH_IDLE: if (req_valid) begin
          mem_sel_n <= 1'b0;
          mem_sel   <= 1'b1;
          if (req_write) begin
            mem_we_n  <= 1'b0;
            mem_dq_oe <= 1'b1;
            ph        <= PH_WRITE;
          end else begin
            mem_oe_n  <= 1'b0;
            ph        <= PH_READ;
          end
        end
        PH_READ: if (last) begin
          mem_oe_n  <= 1'b1;
          mem_sel_n <= 1'b1;
          mem_sel   <= 1'b0;
          rsp_valid <= 1'b1;
          ph        <= PH_FLOAT;
        end
        PH_WRITE: if (last) begin
          mem_we_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          mem_sel_n <= 1'b1;
          mem_sel   <= 1'b0;
          rsp_valid <= 1'b1;
          ph        <= PH_IDLE;
        end
        PH_FLOAT: if (last) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_we_oe_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  p_we_selected_driven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_sel_n && mem_sel && mem_dq_oe));

  p_write_end_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_dq_oe && mem_sel_n && !mem_sel && rsp_valid));

  p_float_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (!req_ready && !mem_dq_oe));

  p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_we_n && mem_oe_n && !mem_dq_oe && mem_sel_n && !mem_sel));

  p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_ctl_data.sv
module sram_ctl_data #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_rdata  <= '0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (capture) rsp_rdata <= mem_dq_in;
    end
  end

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rsp_rdata));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 10,
  parameter int T_AA_NS  = 15,  // address to valid data
  parameter int T_OA_NS  = 8,   // output enable to valid data
  parameter int T_RC_NS  = 15,  // read cycle
  parameter int T_WP_NS  = 12,  // write strobe low
  parameter int T_DS_NS  = 8,   // data setup to strobe rise
  parameter int T_AW_NS  = 12,  // address valid to strobe rise
  parameter int T_WC_NS  = 15,  // write cycle
  parameter int T_OZ_NS  = 7    // outputs float after enable rises
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int unsigned RD_CYC = umax(umax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OA_NS, CLK_NS)),
                                        ns2cyc(T_RC_NS, CLK_NS));
  localparam int unsigned WR_CYC = umax(umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS)),
                                        umax(ns2cyc(T_AW_NS, CLK_NS), ns2cyc(T_WC_NS, CLK_NS)));
  localparam int unsigned FL_CYC = ns2cyc(T_OZ_NS, CLK_NS);
  localparam int unsigned MAX_CYC = umax(umax(RD_CYC, WR_CYC), FL_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  logic             accept, capture, load, last;
  logic [CNT_W-1:0] load_val;

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .last(last)
  );

  sram_ctl_seq #(
    .CNT_W(CNT_W), .RD_CYC(int'(RD_CYC)), .WR_CYC(int'(WR_CYC)), .FL_CYC(int'(FL_CYC))
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write), .last(last),
    .req_ready(req_ready), .accept(accept), .capture(capture), .load(load),
    .load_val(load_val), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .rsp_valid(rsp_valid)
  );

  sram_ctl_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .rsp_rdata(rsp_rdata)
  );

  // address and data are frozen across the whole write strobe
  p_waddr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

  p_wdata_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

  // address frozen while the memory outputs are enabled
  p_raddr_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

  p_read_strobes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_sel_n && mem_sel));

endmodule

// File: tb/sram_ctl_test.sv
module sram_ctl_test;

  localparam int CLK_NS = 10;
  localparam int T_AA = 15, T_OA = 8, T_RC = 15;
  localparam int T_WP = 12, T_DS = 8, T_AW = 12, T_WC = 15, T_OZ = 7;
  localparam int NLOC = 8192;

  function automatic int c2(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int AA_C = (T_AA + CLK_NS - 1) / CLK_NS;
  localparam int OA_C = (T_OA + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic [12:0] mem_addr;
  logic mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0] mem_dq_out, mem_dq_in;

  always #(CLK_NS/2) clk = ~clk;

  sram_ctl #(.CLK_NS(CLK_NS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 1'b0;
  int rd_c, wr_c, fl_c;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] cells [0:NLOC-1];
  logic [7:0] expect_mem [0:NLOC-1];
  int addr_age = 0, oe_age = 0, oe_hi_age = 1000, we_cnt = 0;
  logic [12:0] prev_addr = '0, w_addr = '0;
  logic [7:0] w_data = '0;
  bit w_ok = 1'b0;
  logic sel_c;

  assign sel_c = !mem_sel_n && mem_sel;
  always_comb begin
    if (sel_c && !mem_oe_n && mem_we_n && addr_age >= AA_C && oe_age >= OA_C)
      mem_dq_in = cells[mem_addr];
    else
      mem_dq_in = 8'hC3;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe) begin
        chk(!(sel_c && !mem_oe_n), "R7 bus driven with outputs on", 1, 0);
        chk(oe_hi_age >= fl_c, "R6 float gap", oe_hi_age, fl_c);
      end
      addr_age  = (mem_addr == prev_addr) ? (addr_age < 1000 ? addr_age + 1 : addr_age) : 1;
      prev_addr = mem_addr;
      oe_age    = !mem_oe_n ? oe_age + 1 : 0;
      oe_hi_age = mem_oe_n ? (oe_hi_age < 1000 ? oe_hi_age + 1 : oe_hi_age) : 0;
      if (!mem_we_n) begin
        if (we_cnt == 0) begin
          w_addr = mem_addr; w_data = mem_dq_out; w_ok = 1'b1;
        end else if (mem_addr != w_addr || mem_dq_out != w_data) w_ok = 1'b0;
        if (!sel_c || !mem_dq_oe || !mem_oe_n) w_ok = 1'b0;
        we_cnt++;
      end else if (we_cnt > 0) begin
        chk(we_cnt * CLK_NS >= T_WP, "R3 strobe width", we_cnt * CLK_NS, T_WP);
        chk(we_cnt * CLK_NS >= T_DS, "R3 data setup", we_cnt * CLK_NS, T_DS);
        chk(we_cnt * CLK_NS >= T_AW, "R3 address to end", we_cnt * CLK_NS, T_AW);
        chk(we_cnt * CLK_NS >= T_WC, "R3 write cycle", we_cnt * CLK_NS, T_WC);
        chk(w_ok, "R3 steady address/data/select", 0, 1);
        chk(!mem_dq_oe && !sel_c, "R4 release with strobe rise", mem_dq_oe, 0);
        cells[w_addr] = w_data;
        we_cnt = 0;
      end
    end
  end

  // ---------------- host operations ----------------
  task automatic do_op(input bit w, input logic [12:0] a, input logic [7:0] d);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!rsp_valid && n < 64) begin
      @(negedge clk);
      n++;
    end
    // R9 R11: pulse arrives after the rounded-up cycle count
    chk(n == (w ? wr_c : rd_c) + 1, "R9 R11 latency", n, (w ? wr_c : rd_c) + 1);
    chk(mem_we_n && mem_oe_n && !mem_dq_oe && mem_sel_n && !mem_sel,
        "R8 strobes quiet after cycle", {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b110);
    if (w) expect_mem[a] = d;
    else chk(rsp_rdata == expect_mem[a], "R5 read data", rsp_rdata, expect_mem[a]);
    @(negedge clk);
    chk(!rsp_valid, "R9 single pulse", rsp_valid, 0);
  endtask

  function automatic logic [7:0] pat1(input int a);
    return 8'((a * 37 + 11) ^ (a >> 8));
  endfunction
  function automatic logic [7:0] pat2(input int a);
    return 8'(~a ^ (a >> 5) ^ 8'h5A);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] kept;
    int busy_ok;
    rd_c = mx(mx(c2(T_AA), c2(T_OA)), c2(T_RC));
    wr_c = mx(mx(c2(T_WP), c2(T_DS)), mx(c2(T_AW), c2(T_WC)));
    fl_c = c2(T_OZ);
    // R11: the defaults at a 10 ns clock
    chk(rd_c == 2 && wr_c == 2 && fl_c == 1, "R11 derived counts", rd_c * 100 + wr_c * 10 + fl_c, 221);

    repeat (4) @(negedge clk);
    chk(mem_we_n && mem_oe_n && mem_sel_n && !mem_sel && !mem_dq_oe && req_ready && !rsp_valid,
        "R1 state in reset", 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_we_n && mem_oe_n && mem_sel_n && !mem_sel && !mem_dq_oe && req_ready && !rsp_valid,
        "R1 state after reset", 0, 1);

    // full sweep: fill then read back
    for (int a = 0; a < NLOC; a++) do_op(1'b1, 13'(a), pat1(a));
    for (int a = 0; a < NLOC; a++) do_op(1'b0, 13'(a), 8'h00);

    // alternating write/read at scattered addresses (turnaround R6)
    for (int k = 0; k < 256; k++) begin
      do_op(1'b1, 13'(k * 32 + 7), pat2(k));
      do_op(1'b0, 13'(k * 32 + 7), 8'h00);
      do_op(1'b0, 13'(k * 32 + 8), 8'h00);
    end

    // R10: read byte survives a following write
    do_op(1'b0, 13'd100, 8'h00);
    kept = rsp_rdata;
    do_op(1'b1, 13'd200, 8'hA7);
    chk(rsp_rdata == kept, "R10 read byte held", rsp_rdata, kept);

    // R2: request presented while busy is not taken
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 13'd5; req_wdata = 8'h00;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_write = 1'b1; req_addr = 13'd6; req_wdata = ~expect_mem[6];
    busy_ok = 1;
    while (!rsp_valid) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
    end
    if (req_ready) busy_ok = 0;
    req_valid = 1'b0;
    chk(busy_ok == 1, "R2 ready low while busy", busy_ok, 1);
    repeat (4) @(negedge clk);
    do_op(1'b0, 13'd6, 8'h00);
    chk(rsp_rdata == expect_mem[6], "R2 withdrawn request had no effect", rsp_rdata, expect_mem[6]);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule